// File: doc/BRIEF.md
# Function-Level Reset Status Tracker

This block keeps one reset-in-progress bit for each of up to 256 PCIe functions. The DMA side raises a one-cycle set pulse when a function enters reset and a one-cycle clear pulse when that reset is over. Both pulses carry the 8-bit function number on a shared ID input. The full bitmap is presented as an output, so user logic can see which functions are currently in reset.

When user logic has finished its own cleanup for a function, it raises a completion request on one of several request lanes, tagged with that function number. The block admits a request only if the function's status bit is set and the completion queue has room. Admitted requests wait in a small FIFO. The block drains that FIFO at most one entry per cycle, and each entry becomes a one-cycle done pulse carrying the function number. A request the block turns down produces a one-cycle reject flag on its lane, and no done pulse follows it.

Top module: `fn_reset_tracker`

## Requirements
- R1: A one-cycle `evt_set` makes `status_map[evt_fn]` read 1 from the cycle after the pulse.
- R2: A one-cycle `evt_clr` without `evt_set` makes `status_map[evt_fn]` read 0 from the cycle after the pulse.
- R3: When `evt_set` and `evt_clr` are high in the same cycle, the addressed bit reads 1 in the cycle after.
- R4: Set and clear pulses change only the entry selected by `evt_fn`. With neither pulse high, the whole bitmap holds its value.
- R5: A request on lane k (`cmpl_req[k]`, function `cmpl_fn[8k+7:8k]`) whose status bit is 0 before the clock edge is rejected. `cmpl_reject[k]` is high for exactly the following cycle, and no done pulse is produced for that request.
- R6: The completion queue holds DEPTH entries (default 4). The block reads the occupancy before the edge and admits lanes in rising index order. A lane is admitted only while that occupancy plus the lanes already admitted in the same cycle is below DEPTH. A lane that does not fit is rejected as in R5.
- R7: Each admitted request produces exactly one `done_vld` pulse, at the earliest two cycles after the request cycle, with its function on `done_fn` in that cycle. Pulses come out in the order the requests were admitted (lane 0 before lane 1 within a cycle), at most one per cycle, and `done_vld` is high only when an entry is emitted.
- R8: While `rst_n` is low at a clock edge, every status bit, `done_vld`, `cmpl_reject` and the queue are cleared. Set, clear and request inputs have no effect during reset.
- R9: Clearing a function's status bit after its request has been admitted does not cancel the queued done pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_set | input | 1 | One-cycle pulse: function on evt_fn enters reset |
| evt_clr | input | 1 | One-cycle pulse: function on evt_fn leaves reset |
| evt_fn | input | 8 | Function number for set/clear pulses |
| cmpl_req | input | LANES | Per-lane cleanup-complete request |
| cmpl_fn | input | 8*LANES | Function number per lane, lane k in bits 8k+7:8k |
| status_map | output | 256 | Reset-in-progress bit per function |
| done_vld | output | 1 | One-cycle completion pulse |
| done_fn | output | 8 | Function number of the completion |
| cmpl_reject | output | LANES | One-cycle reject flag per lane |

## Verification
The bench goes after the cases where a set and a clear arrive together, and where a request arrives in the same cycle that its status bit is being set. A design that let the clear win, or that looked at the bit after it had been updated, would show a wrong bitmap or a wrong accept or reject. Two-lane bursts push the queue past its depth. A design that ignored the cycle's earlier admissions, or got the lane order wrong, would drop entries, duplicate them, or emit them out of order. A clear issued while a done is still queued, and a reset taken with the queue non-empty, check that a queued completion survives the clear and that reset leaves no stale done pulse behind.

// File: rtl/frt_pkg.sv
// Shared widths and types for the function-level reset tracker.
// Assumes 8-bit function numbers, giving 256 tracked functions.
package frt_pkg;
    localparam int FN_W   = 8;
    localparam int NUM_FN = 1 << FN_W;
    typedef logic [FN_W-1:0] fn_id_t;
endpackage

// File: rtl/frt_status_map.sv
// Per-function reset-in-progress bitmap.
// Each entry is one flop, set or cleared only when the shared function ID
// selects it. A set in the same cycle as a clear wins.
// Assumes set and clear pulses are single-cycle and share one ID input.
module frt_status_map #(
    parameter int FN_W   = 8,
    parameter int NUM_FN = 1 << FN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_set,
    input  logic              evt_clr,
    input  logic [FN_W-1:0]   evt_fn,
    output logic [NUM_FN-1:0] status_q
);

    for (genvar g = 0; g < NUM_FN; g++) begin : g_entry
        logic hit;
        assign hit = (evt_fn == FN_W'(g));

        // Update one status entry from the set/clear pulses, set first.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                status_q[g] <= 1'b0;
            end else if (evt_set && hit) begin
                status_q[g] <= 1'b1;
            end else if (evt_clr && hit) begin
                status_q[g] <= 1'b0;
            end
        end
    end

    AST_SET_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
        evt_set |=> status_q[$past(evt_fn)]); // R1
    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_clr && !evt_set) |=> !status_q[$past(evt_fn)]); // R2
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_clr && evt_set) |=> status_q[$past(evt_fn)]); // R3
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_set && !evt_clr) |=> $stable(status_q)); // R4

endmodule

// File: rtl/frt_admit.sv
// Admission of cleanup-complete requests into the completion queue.
// A lane is admitted when its function's status bit is set and the queue
// still has room after the lower-numbered lanes admitted this cycle.
// Purely combinational. Occupancy is the registered count before the edge.
module frt_admit #(
    parameter int FN_W   = 8,
    parameter int NUM_FN = 1 << FN_W,
    parameter int LANES  = 2,
    parameter int DEPTH  = 4,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic [LANES-1:0]      req,
    input  logic [LANES*FN_W-1:0] req_fn,
    input  logic [NUM_FN-1:0]     status_map,
    input  logic [CNT_W-1:0]      occupancy,
    output logic [LANES-1:0]      accept
);

    logic [CNT_W:0] taken;

    // Walk lanes in index order, granting while the queue has space.
    always_comb begin
        taken  = '0;
        accept = '0;
        for (int k = 0; k < LANES; k++) begin
            if (req[k] && status_map[req_fn[k*FN_W +: FN_W]] &&
                (({1'b0, occupancy} + taken) < (CNT_W+1)'(DEPTH))) begin
                accept[k] = 1'b1;
                taken     = taken + (CNT_W+1)'(1);
            end
        end
    end

endmodule

// File: rtl/frt_done_queue.sv
// Completion FIFO with a registered done-pulse output.
// Accepts up to LANES pushes per cycle, in lane order, and pops at most
// one entry per cycle into done_vld/done_fn.
// Assumes DEPTH is a power of two, DEPTH >= 2, LANES <= DEPTH, and that the
// caller never pushes more than the free space.
module frt_done_queue #(
    parameter int FN_W  = 8,
    parameter int LANES = 2,
    parameter int DEPTH = 4,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [LANES-1:0]      push,
    input  logic [LANES*FN_W-1:0] push_fn,
    output logic [CNT_W-1:0]      occupancy,
    output logic                  done_vld,
    output logic [FN_W-1:0]       done_fn
);

    localparam int PTR_W = $clog2(DEPTH);

    logic [FN_W-1:0]  mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic [PTR_W-1:0] wslot [LANES];
    logic [CNT_W-1:0] npush;
    logic             pop;

    assign pop = (occupancy != '0);

    // Give each pushing lane the next free slot after the earlier lanes.
    always_comb begin
        npush = '0;
        for (int k = 0; k < LANES; k++) begin
            wslot[k] = wptr + PTR_W'(npush);
            if (push[k]) begin
                npush = npush + CNT_W'(1);
            end
        end
    end

    // Write admitted function numbers into their slots.
    always_ff @(posedge clk) begin
        for (int k = 0; k < LANES; k++) begin
            if (push[k]) begin
                mem[wslot[k]] <= push_fn[k*FN_W +: FN_W];
            end
        end
    end

    // Move pointers and count, and register the popped entry as a done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr      <= '0;
            rptr      <= '0;
            occupancy <= '0;
            done_vld  <= 1'b0;
            done_fn   <= '0;
        end else begin
            wptr      <= wptr + PTR_W'(npush);
            occupancy <= occupancy + npush - CNT_W'(pop);
            done_vld  <= pop;
            if (pop) begin
                rptr    <= rptr + PTR_W'(1);
                done_fn <= mem[rptr];
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        occupancy <= CNT_W'(DEPTH)); // R6
    AST_DONE_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        done_vld |-> ($past(occupancy) != '0)); // R7

endmodule

// File: rtl/fn_reset_tracker.sv
// Function-level reset status tracker, top level.
// Holds a reset-in-progress bitmap driven by set/clear pulses, admits
// per-lane cleanup-complete requests for functions in reset, and returns
// each admitted request as a one-cycle tagged done pulse.
// Assumes single-cycle input pulses and a synchronous active-low reset.
module fn_reset_tracker
    import frt_pkg::*;
#(
    parameter int LANES = 2,
    parameter int DEPTH = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  evt_set,
    input  logic                  evt_clr,
    input  logic [FN_W-1:0]       evt_fn,
    input  logic [LANES-1:0]      cmpl_req,
    input  logic [LANES*FN_W-1:0] cmpl_fn,
    output logic [NUM_FN-1:0]     status_map,
    output logic                  done_vld,
    output logic [FN_W-1:0]       done_fn,
    output logic [LANES-1:0]      cmpl_reject
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [LANES-1:0] accept;
    logic [CNT_W-1:0] occupancy;

    frt_status_map #(.FN_W(FN_W), .NUM_FN(NUM_FN)) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_set  (evt_set),
        .evt_clr  (evt_clr),
        .evt_fn   (evt_fn),
        .status_q (status_map)
    );

    frt_admit #(
        .FN_W(FN_W), .NUM_FN(NUM_FN), .LANES(LANES), .DEPTH(DEPTH), .CNT_W(CNT_W)
    ) u_admit (
        .req        (cmpl_req),
        .req_fn     (cmpl_fn),
        .status_map (status_map),
        .occupancy  (occupancy),
        .accept     (accept)
    );

    frt_done_queue #(
        .FN_W(FN_W), .LANES(LANES), .DEPTH(DEPTH), .CNT_W(CNT_W)
    ) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (accept),
        .push_fn   (cmpl_fn),
        .occupancy (occupancy),
        .done_vld  (done_vld),
        .done_fn   (done_fn)
    );

    // Flag requests that were not admitted, one cycle after they arrived.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmpl_reject <= '0;
        end else begin
            cmpl_reject <= cmpl_req & ~accept;
        end
    end

    AST_REJECT_UNSET: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl_req[0] && !status_map[cmpl_fn[FN_W-1:0]]) |=> cmpl_reject[0]); // R5
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (status_map == '0 && !done_vld && cmpl_reject == '0)); // R8

endmodule

// File: tb/sim_fn_reset_tracker.sv
// Bench for fn_reset_tracker: behavioural reference model compared each cycle.
module sim_fn_reset_tracker;
    localparam int CLK_PERIOD = 10;
    localparam int L  = 2;
    localparam int D  = 4;
    localparam int FW = 8;
    localparam int NF = 256;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            evt_set = 1'b0, evt_clr = 1'b0;
    logic [FW-1:0]   evt_fn = '0;
    logic [L-1:0]    cmpl_req = '0;
    logic [L*FW-1:0] cmpl_fn = '0;
    logic [NF-1:0]   status_map;
    logic            done_vld;
    logic [FW-1:0]   done_fn;
    logic [L-1:0]    cmpl_reject;

    fn_reset_tracker #(.LANES(L), .DEPTH(D)) u0 (
        .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .evt_clr(evt_clr),
        .evt_fn(evt_fn), .cmpl_req(cmpl_req), .cmpl_fn(cmpl_fn),
        .status_map(status_map), .done_vld(done_vld), .done_fn(done_fn),
        .cmpl_reject(cmpl_reject)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    n_chk = 0, n_fail = 0;
    string map_tag = "R8", done_tag = "R7", rej_tag = "R8";

    // Reference model state.
    bit           mref [NF];
    int           q [$];
    bit           m_dv = 0;
    int           m_dfn = 0;
    bit [L-1:0]   m_rej = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (mref[i]) mref[i] = 0;
            q.delete();
            m_dv = 0;
            m_rej = '0;
        end else begin
            int sz;
            int taken;
            sz = q.size();
            taken = 0;
            if (sz > 0) begin
                m_dv  = 1;
                m_dfn = q.pop_front();
            end else begin
                m_dv = 0;
            end
            for (int k = 0; k < L; k++) begin
                int f;
                f = int'(cmpl_fn[k*FW +: FW]);
                m_rej[k] = 0;
                if (cmpl_req[k]) begin
                    if (mref[f] && (sz + taken < D)) begin
                        q.push_back(f);
                        taken++;
                    end else begin
                        m_rej[k] = 1;
                    end
                end
            end
            if (evt_set) mref[evt_fn] = 1;
            else if (evt_clr) mref[evt_fn] = 0;
        end
    end

    task automatic chk(input bit ok, input string tag,
                       input logic [NF-1:0] act, input logic [NF-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic compare();
        logic [NF-1:0] mv;
        for (int i = 0; i < NF; i++) mv[i] = mref[i];
        chk(status_map === mv, map_tag, status_map, mv);
        if (m_dv)
            chk(done_vld === 1'b1 && done_fn === FW'(m_dfn), done_tag,
                NF'({done_vld, done_fn}), NF'({1'b1, FW'(m_dfn)}));
        else
            chk(done_vld === 1'b0, done_tag, NF'(done_vld), '0);
        chk(cmpl_reject === m_rej, rej_tag, NF'(cmpl_reject), NF'(m_rej));
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare();
        evt_set = 0; evt_clr = 0; cmpl_req = '0;
    endtask

    task automatic ev(input bit s, input bit c, input int f);
        evt_set = s; evt_clr = c; evt_fn = FW'(f);
    endtask

    task automatic rq(input int k, input int f);
        cmpl_req[k] = 1'b1;
        cmpl_fn[k*FW +: FW] = FW'(f);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        // R8: inputs during reset have no effect.
        @(negedge clk);
        ev(1, 0, 3); rq(0, 3);
        tick();
        ev(1, 0, 4);
        tick();
        tick();
        rst_n = 1;

        // R1 and R4: set single entries at the edges of the ID range.
        map_tag = "R1"; rej_tag = "R5";
        ev(1, 0, 5);   tick();
        ev(1, 0, 0);   tick();
        ev(1, 0, 255); tick();
        map_tag = "R4"; tick();

        // R2: clear one entry.
        map_tag = "R2";
        ev(0, 1, 5); tick();

        // R3: set and clear together, on a clear bit and on a set bit.
        map_tag = "R3";
        ev(1, 1, 9); tick();
        ev(1, 1, 0); tick();
        map_tag = "R4";

        // R5: unset function rejected; set function admitted on lane 1.
        rej_tag = "R5";
        rq(0, 42); rq(1, 0); tick();
        done_tag = "R7"; tick();
        tick();
        // R5: request in the same cycle as its set is still rejected.
        ev(1, 0, 77); rq(0, 77); tick();
        tick();

        // R6: two-lane bursts overfill the queue.
        rej_tag = "R6";
        rq(0, 255); rq(1, 0); tick();
        rq(0, 9);   rq(1, 77); tick();
        rq(0, 0);   rq(1, 255); tick();
        rq(0, 77);  rq(1, 9); tick();
        done_tag = "R7";
        repeat (6) tick();

        // R9: clear in the admitting cycle does not cancel the done pulse.
        done_tag = "R9"; rej_tag = "R9"; map_tag = "R9";
        ev(0, 1, 255); rq(0, 255); tick();
        rq(1, 255); tick();
        repeat (3) tick();

        // R8: reset taken with a non-empty queue.
        done_tag = "R8"; rej_tag = "R8"; map_tag = "R8";
        rq(0, 0); rq(1, 9); tick();
        rq(0, 77); rq(1, 0); tick();
        rst_n = 0; tick();
        rst_n = 1;
        repeat (4) tick();

        summary();
    end

endmodule